// File: doc/BRIEF.md
# Preloaded Compare Channel with Group Gating

This block is an extra compare channel for a timer that shares a free-running counter with three other channels. It holds a compare value and produces its own reference waveform, high while the shared counter is strictly below the active compare value. That waveform can be ANDed into the reference outputs of the three other channels, each selected by its own group-enable bit. The typical use is to shape or clip the PWM waveforms of channels 1 to 3 with a common window.

The compare value and the three enable bits each have a shadow (preload) copy and an active copy. The compare value moves from shadow to active either on every write (preload off) or only on an update-event pulse (preload on). Each enable bit follows the preload setting of the channel it gates, so the three bits can change at different moments. The write port is a plain register write: the block accepts a write in any cycle and never stalls, so it has no back-pressure. A read word shows the shadow contents in a fixed layout.

Top module: `gated_cmp_channel`

## Requirements
- R1: After reset the active and shadow compare values and all enable bits are zero, so `rd_word` is 0, `ref5_o` is low and each `gref_o[i]` equals `tgt_ref_i[i]`.
- R2: With `pre5_i` low, a write of `wr_cmp` becomes the active compare value at the clock edge of the write, visible on `ref5_o` in the next cycle.
- R3: With `pre5_i` high, a written compare value stays in the shadow copy and the active value is unchanged until a cycle with `upd_i` high copies the shadow into it.
- R4: When a write and `upd_i` occur in the same cycle with `pre5_i` high, the active value takes the shadow contents from before the write, and the new value lands in the shadow.
- R5: `ref5_o` is high when `cnt_i` is strictly less than the active compare value and low otherwise (zero compare value gives a constantly low reference).
- R6: When active enable bit i is 1, `gref_o[i]` is `tgt_ref_i[i] & ref5_o`.
- R7: When active enable bit i is 0, `gref_o[i]` equals `tgt_ref_i[i]` whatever `ref5_o` is.
- R8: Enable bit i loads from `wr_gen[i]` at once when `pre_tgt_i[i]` is low and only on `upd_i` when it is high, independently for each i, with the same same-cycle rule as R4.
- R9: `rd_word` shows the shadow compare value in bits 15:0 and the shadow enable bits for channels 1, 2, 3 in bits 29, 30, 31; bits 28:16 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| cnt_i | input | 16 | Shared counter value |
| upd_i | input | 1 | Update-event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_cmp | input | 16 | Compare value to write |
| wr_gen | input | 3 | Group-enable bits to write (bit 0 = channel 1) |
| pre5_i | input | 1 | Preload enable for the compare value |
| pre_tgt_i | input | 3 | Preload enable of each gated channel |
| tgt_ref_i | input | 3 | Reference waveforms of channels 1 to 3 |
| ref5_o | output | 1 | Channel-5 reference |
| gref_o | output | 3 | Combined references of channels 1 to 3 |
| rd_word | output | 32 | Read view of the shadow register word |

## Verification
On every cycle the assertions check the loading rules (immediate load, hold while preloaded, copy of the old shadow on update), the low reference for a zero compare value, the pass-through and AND forms of the gating, and the zero bits of the read word. The bench scenarios show what needs chosen stimulus: the exact counter threshold where `ref5_o` falls, a write colliding with an update, and one enable bit held by its channel's preload while the other two change at once.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  parameter int CMP_W   = 16;
  parameter int N_TGT   = 3;
  parameter int WORD_W  = 32;
  parameter int GEN_LSB = 29;
  localparam int GAP_W  = GEN_LSB - CMP_W;
endpackage

// File: rtl/gcc_preload_reg.sv
module gcc_preload_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         pre_en,
  input  logic         upd,
  output logic [W-1:0] shd,
  output logic [W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
      act <= '0;
    end else begin
      if (wr_en) shd <= wr_val;
      if (!pre_en) begin
        if (wr_en) act <= wr_val;
      end else if (upd) begin
        act <= shd;
      end
    end
  end
endmodule

// File: rtl/gcc_compare.sv
module gcc_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         ref_o
);
  always_comb ref_o = (cnt < cmp);
endmodule

// File: rtl/gcc_gate.sv
module gcc_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] tgt_ref,
  input  logic         win,
  output logic [N-1:0] gref
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    always_comb gref[i] = en[i] ? (tgt_ref[i] & win) : tgt_ref[i];
  end
endmodule

// File: rtl/gated_cmp_channel.sv
module gated_cmp_channel
  import gcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMP_W-1:0]  cnt_i,
  input  logic              upd_i,
  input  logic              wr_en,
  input  logic [CMP_W-1:0]  wr_cmp,
  input  logic [N_TGT-1:0]  wr_gen,
  input  logic              pre5_i,
  input  logic [N_TGT-1:0]  pre_tgt_i,
  input  logic [N_TGT-1:0]  tgt_ref_i,
  output logic              ref5_o,
  output logic [N_TGT-1:0]  gref_o,
  output logic [WORD_W-1:0] rd_word
);
  logic [CMP_W-1:0] cmp_shd, cmp_act;
  logic [N_TGT-1:0] gen_shd, gen_act;

  gcc_preload_reg #(.W(CMP_W)) u_cmp_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_cmp),
    .pre_en(pre5_i), .upd(upd_i), .shd(cmp_shd), .act(cmp_act)
  );

  for (genvar i = 0; i < N_TGT; i++) begin : g_en
    gcc_preload_reg #(.W(1)) u_en_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_gen[i]),
      .pre_en(pre_tgt_i[i]), .upd(upd_i), .shd(gen_shd[i]), .act(gen_act[i])
    );
  end

  gcc_compare #(.W(CMP_W)) u_cmp (
    .cnt(cnt_i), .cmp(cmp_act), .ref_o(ref5_o)
  );

  gcc_gate #(.N(N_TGT)) u_gate (
    .en(gen_act), .tgt_ref(tgt_ref_i), .win(ref5_o), .gref(gref_o)
  );

  always_comb rd_word = {gen_shd, {GAP_W{1'b0}}, cmp_shd};
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker
  import gcc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              upd_i,
  input logic              wr_en,
  input logic [CMP_W-1:0]  wr_cmp,
  input logic              pre5_i,
  input logic [CMP_W-1:0]  cmp_shd,
  input logic [CMP_W-1:0]  cmp_act,
  input logic [N_TGT-1:0]  gen_act,
  input logic [N_TGT-1:0]  tgt_ref_i,
  input logic              ref5_o,
  input logic [N_TGT-1:0]  gref_o,
  input logic [WORD_W-1:0] rd_word
);
  AST_IMMEDIATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pre5_i) |=> (cmp_act == $past(wr_cmp))); // R2
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pre5_i && !upd_i) |=> $stable(cmp_act)); // R3
  AST_UPDATE_OLD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pre5_i && upd_i) |=> (cmp_act == $past(cmp_shd))); // R4
  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !ref5_o); // R5
  AST_GATE_AND: assert property (@(posedge clk) disable iff (!rst_n)
    ((gref_o & gen_act) == (tgt_ref_i & gen_act & {N_TGT{ref5_o}}))); // R6
  AST_GATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((gref_o & ~gen_act) == (tgt_ref_i & ~gen_act))); // R7
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[GEN_LSB-1:CMP_W] == '0)); // R9
endmodule

bind gated_cmp_channel gcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .wr_en(wr_en), .wr_cmp(wr_cmp),
  .pre5_i(pre5_i), .cmp_shd(cmp_shd), .cmp_act(cmp_act), .gen_act(gen_act),
  .tgt_ref_i(tgt_ref_i), .ref5_o(ref5_o), .gref_o(gref_o), .rd_word(rd_word)
);

// File: tb/gated_cmp_channel_test.sv
`timescale 1ns/1ps
module gated_cmp_channel_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cnt_i = 0;
  logic        upd_i = 0;
  logic        wr_en = 0;
  logic [15:0] wr_cmp = 0;
  logic [2:0]  wr_gen = 0;
  logic        pre5_i = 0;
  logic [2:0]  pre_tgt_i = 0;
  logic [2:0]  tgt_ref_i = 0;
  logic        ref5_o;
  logic [2:0]  gref_o;
  logic [31:0] rd_word;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gated_cmp_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i), .wr_en(wr_en),
    .wr_cmp(wr_cmp), .wr_gen(wr_gen), .pre5_i(pre5_i), .pre_tgt_i(pre_tgt_i),
    .tgt_ref_i(tgt_ref_i), .ref5_o(ref5_o), .gref_o(gref_o), .rd_word(rd_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock step with inputs driven at the falling edge; returns at the next falling edge
  task automatic step(input bit we, input logic [15:0] c, input logic [2:0] g, input bit up);
    wr_en = we; wr_cmp = c; wr_gen = g; upd_i = up;
    @(negedge clk);
    wr_en = 0; upd_i = 0;
  endtask

  task automatic ref_at(input string tag, input logic [15:0] c, input bit exp);
    cnt_i = c; #0.5;
    chk(tag, {31'b0, ref5_o}, {31'b0, exp});
  endtask

  task automatic t_reset();
    tgt_ref_i = 3'b111; cnt_i = 0; #0.5;
    chk("R1 rd_word", rd_word, 32'h0);
    chk("R1 ref5", {31'b0, ref5_o}, 32'h0);
    chk("R1 gref", {29'b0, gref_o}, 32'h7);
  endtask

  task automatic t_immediate();
    pre5_i = 0;
    step(1, 16'd100, 3'b000, 0);
    ref_at("R2 below", 16'd99, 1);
    ref_at("R5 equal", 16'd100, 0);
    ref_at("R5 above", 16'd101, 0);
  endtask

  task automatic t_preload();
    pre5_i = 1;
    step(1, 16'd200, 3'b000, 0);
    ref_at("R3 held", 16'd150, 0);
    step(0, 16'd0, 3'b000, 1);
    ref_at("R3 after update", 16'd150, 1);
    ref_at("R5 boundary", 16'd200, 0);
  endtask

  task automatic t_collision();
    pre5_i = 1;
    step(1, 16'd50, 3'b000, 0);
    step(1, 16'd300, 3'b000, 1);
    ref_at("R4 old shadow below", 16'd49, 1);
    ref_at("R4 old shadow at", 16'd50, 0);
    chk("R4 new in shadow", {16'b0, rd_word[15:0]}, 32'd300);
    step(0, 16'd0, 3'b000, 1);
    ref_at("R4 next update", 16'd299, 1);
    pre5_i = 0;
  endtask

  task automatic t_gating();
    pre_tgt_i = 3'b000;
    step(1, 16'd10, 3'b001, 0);
    tgt_ref_i = 3'b111; cnt_i = 5; #0.5;
    chk("R6 window open", {29'b0, gref_o}, 32'h7);
    cnt_i = 20; #0.5;
    chk("R6 ch1 gated", {29'b0, gref_o}, 32'h6);
    tgt_ref_i = 3'b010; #0.5;
    chk("R7 pass", {29'b0, gref_o}, 32'h2);
    step(1, 16'd10, 3'b111, 0);
    tgt_ref_i = 3'b111; cnt_i = 20; #0.5;
    chk("R6 all gated", {29'b0, gref_o}, 32'h0);
    tgt_ref_i = 3'b101; cnt_i = 5; #0.5;
    chk("R6 open follows ref", {29'b0, gref_o}, 32'h5);
  endtask

  task automatic t_enable_preload();
    pre_tgt_i = 3'b100;
    step(1, 16'd10, 3'b000, 0);
    tgt_ref_i = 3'b111; cnt_i = 20; #0.5;
    chk("R8 ch3 held", {29'b0, gref_o}, 32'h3);
    step(0, 16'd0, 3'b000, 1);
    cnt_i = 20; #0.5;
    chk("R8 ch3 after update", {29'b0, gref_o}, 32'h7);
    pre_tgt_i = 3'b000;
  endtask

  task automatic t_layout();
    pre5_i = 0;
    step(1, 16'hFFFF, 3'b111, 0);
    #0.5;
    chk("R9 full word", rd_word, 32'hE000FFFF);
    step(1, 16'h1234, 3'b010, 0);
    #0.5;
    chk("R9 ch2 bit", rd_word, 32'h40001234);
    step(1, 16'h0, 3'b000, 0);
    #0.5;
    chk("R9 cleared", rd_word, 32'h0);
    tgt_ref_i = 3'b011; cnt_i = 0; #0.5;
    chk("R5 zero compare", {31'b0, ref5_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_immediate();
    t_preload();
    t_collision();
    t_gating();
    t_enable_preload();
    t_layout();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule